// File: doc/BRIEF.md
# Split-Enable DAC Input Word Latch

This block is the digital front end of a 10-bit digital-to-analog converter that receives its code from an 8-bit processor bus. The code is held in two latch groups, each with its own active-low open strobe. The upper group holds code bits 9:8, loaded from bus lines 7:6. The lower group holds code bits 7:0, loaded straight from bus lines 7:0. While a strobe is low, its group follows the bus. When the strobe rises, the group keeps the last value it followed.

A full word can be written in two bus cycles: the upper strobe first, then the lower strobe. It can also be written in one step. In that case a pre-load strobe first parks bus lines 7:6 in a small holding group. A load strobe then opens both code groups together. The upper group takes its bits from the holding group and the lower group takes its bits from the bus, so all ten bits move in the same clock cycle.

The held code is presented two ways, chosen by a mode input:
- an unsigned view;
- an offset-binary signed view, in which code 512 means zero.

The block runs on one system clock. All four strobes pass through a two-flop synchronizer, and the bus passes through a matching two-stage delay so that it stays aligned with the strobes.

A timing monitor runs once for each of three strobes: upper-open, lower-open and pre-load. Each monitor is a three-state machine:
- **MON_IDLE**: the strobe is high and the post-edge window is over. The transition *open* leads to MON_OPEN when the strobe is sampled low.
- **MON_OPEN**: counts the low cycles. The transition *close* leads to MON_HOLD when the strobe is sampled high. At that moment the low-pulse length and the bus stability count are checked.
- **MON_HOLD**: counts the post-edge cycles and flags any bus change during them. The transition *window done* leads back to MON_IDLE after HOLD_CYC cycles. The transition *reopen* leads to MON_OPEN if the strobe falls again first.

Any violation sets a sticky error flag.

Top module: `dac_word_latch`

## Requirements
- R1: After reset, `code_q` is 0, `timing_err` is 0, and `view_q` is 0 in unipolar mode.
- R2: While `hi_open_n` (or `load_n`) is sampled low, `code_q[9:8]` follows the bus: bus line 7 goes to code bit 9 and bus line 6 goes to code bit 8. When opened through `hi_open_n`, `code_q[7:0]` is not changed.
- R3: While `lo_open_n` (or `load_n`) is sampled low, `code_q[7:0]` tracks `bus_d[7:0]` bit for bit.
- R4: While a group's strobes are high, bus changes have no effect on that group's bits of `code_q`.
- R5: On the strobe's rising edge, a group keeps the bus value it held at that edge. Upper strobe then lower strobe yields the complete 10-bit word.
- R6: While `pre_n` is low, bus lines 7:6 go into a holding group and `code_q` does not change. While `load_n` is low, `code_q` becomes {holding group, `bus_d[7:0]`}, with all ten bits changing in the same cycle.
- R7: A change on the bus or on a strobe reaches `code_q` at the third rising clock edge after it is applied.
- R8: With `bipolar` = 0, `view_q` equals `code_q` zero-extended to 11 bits.
- R9: With `bipolar` = 1, `view_q` equals `code_q` − 512 in 11-bit two's complement: code 0 gives −512, code 512 gives 0, and code 1023 gives 511.
- R10: If, at a strobe's rising edge, the bus has been stable for fewer than SETUP_CYC = ceil(SETUP_PS/CLK_PERIOD_PS) cycles, `timing_err` is set.
- R11: A bus change within HOLD_CYC = ceil(HOLD_PS/CLK_PERIOD_PS) cycles after a strobe's rising edge sets `timing_err`.
- R12: A strobe low pulse shorter than PW_CYC = ceil(PULSE_PS/CLK_PERIOD_PS) cycles sets `timing_err`.
- R13: `timing_err` stays set until `err_clr` is sampled high, which clears it at the next edge. If a new violation occurs in the same cycle, setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Processor data bus |
| hi_open_n | input | 1 | Active-low open strobe for code bits 9:8 |
| lo_open_n | input | 1 | Active-low open strobe for code bits 7:0 |
| pre_n | input | 1 | Active-low strobe for the upper-bit holding group |
| load_n | input | 1 | Active-low strobe that opens both groups, upper bits taken from the holding group |
| bipolar | input | 1 | Selects the offset-binary signed view |
| err_clr | input | 1 | Clears the sticky timing error |
| code_q | output | 10 | Held converter code |
| view_q | output | 11 | Signed view of the code |
| timing_err | output | 1 | Sticky timing-violation flag |

## Verification
The bench builds the block with its default parameters:
- a 20 000 ps clock period;
- 100 000 ps setup, 50 000 ps hold and 150 000 ps pulse limits.

These give windows of 5, 3 and 8 cycles, short enough that each window can be violated on purpose within a few cycles, and they round the hold window up from 2.5 cycles. The 8-bit bus and the 2-bit upper group give the 10-bit code, so the offset-binary corners at codes 0, 512 and 1023 can all be reached by single-step writes.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    typedef enum logic [1:0] {
        MON_IDLE = 2'd0,
        MON_OPEN = 2'd1,
        MON_HOLD = 2'd2
    } mon_state_t;

    // Whole clock cycles needed to cover a span, rounded up.
    function automatic int ps_to_cycles(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/dlw_pipe.sv
module dlw_pipe #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dlw_latch_group.sv
module dlw_latch_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Follows d on every cycle the strobe is sampled low; holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (!open_n) q <= d;
    end
endmodule

// File: rtl/dlw_edge_mon.sv
module dlw_edge_mon
    import dlw_pkg::*;
#(
    parameter int SETUP_CYC = 5,
    parameter int HOLD_CYC  = 3,
    parameter int PW_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic data_chg,
    output logic viol
);
    localparam int SW = $clog2(SETUP_CYC + 2);
    localparam int HW = $clog2(HOLD_CYC + 2);
    localparam int LW = $clog2(PW_CYC + 2);
    localparam logic [SW-1:0] S_MAX = '1;
    localparam logic [LW-1:0] L_MAX = '1;

    mon_state_t    st, nxt;
    logic [SW-1:0] stab_cnt;
    logic [HW-1:0] hold_cnt;
    logic [LW-1:0] low_cnt;

    always_comb begin
        nxt  = st;
        viol = 1'b0;
        unique case (st)
            MON_IDLE: if (!en_n) nxt = MON_OPEN;
            MON_OPEN: if (en_n) begin
                nxt  = MON_HOLD;
                viol = (int'(low_cnt) < PW_CYC) || (int'(stab_cnt) < SETUP_CYC);
            end
            MON_HOLD: begin
                viol = data_chg;
                if (!en_n)                               nxt = MON_OPEN;
                else if (int'(hold_cnt) + 1 >= HOLD_CYC) nxt = MON_IDLE;
            end
            default: nxt = MON_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= MON_IDLE;
            stab_cnt <= '0;
            hold_cnt <= '0;
            low_cnt  <= '0;
        end else begin
            st <= nxt;
            if (data_chg)             stab_cnt <= '0;
            else if (stab_cnt != S_MAX) stab_cnt <= stab_cnt + 1'b1;
            if (st != MON_OPEN)         low_cnt <= LW'(1);
            else if (low_cnt != L_MAX)  low_cnt <= low_cnt + 1'b1;
            if (st != MON_HOLD)         hold_cnt <= '0;
            else                        hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dac_word_latch.sv
module dac_word_latch
    import dlw_pkg::*;
#(
    parameter int BUS_W         = 8,
    parameter int HI_W          = 2,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int SETUP_PS      = 100000,
    parameter int HOLD_PS       = 50000,
    parameter int PULSE_PS      = 150000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BUS_W-1:0]             bus_d,
    input  logic                         hi_open_n,
    input  logic                         lo_open_n,
    input  logic                         pre_n,
    input  logic                         load_n,
    input  logic                         bipolar,
    input  logic                         err_clr,
    output logic [BUS_W+HI_W-1:0]        code_q,
    output logic signed [BUS_W+HI_W:0]   view_q,
    output logic                         timing_err
);
    localparam int CODE_W    = BUS_W + HI_W;
    localparam int VIEW_W    = CODE_W + 1;
    localparam int SETUP_CYC = ps_to_cycles(SETUP_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC  = ps_to_cycles(HOLD_PS, CLK_PERIOD_PS);
    localparam int PW_CYC    = ps_to_cycles(PULSE_PS, CLK_PERIOD_PS);
    localparam int N_MON     = 3;
    localparam logic [VIEW_W-1:0] OFFSET = VIEW_W'(1) << (CODE_W - 1);

    logic [3:0]       en_s;
    logic [BUS_W-1:0] bus_s, bus_prev;
    logic             hi_eff_n, lo_eff_n, load_act;
    logic [HI_W-1:0]  pre_q, hi_d, hi_q;
    logic [BUS_W-1:0] lo_q;
    logic [N_MON-1:0] mon_en_n, mon_viol;
    logic             bus_chg;

    // Strobe synchronizer and an equal-depth delay for the bus.
    dlw_pipe #(.W(4), .STAGES(2), .RST_VAL(4'hF)) u_en_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pre_n, load_n, hi_open_n, lo_open_n}), .q(en_s)
    );
    dlw_pipe #(.W(BUS_W), .STAGES(2), .RST_VAL('0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n), .d(bus_d), .q(bus_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_prev <= '0;
        else        bus_prev <= bus_s;
    end

    assign load_act = !en_s[2];
    assign hi_eff_n = en_s[1] & en_s[2];
    assign lo_eff_n = en_s[0] & en_s[2];
    assign hi_d     = load_act ? pre_q : bus_s[BUS_W-1 -: HI_W];
    assign bus_chg  = (bus_s != bus_prev);

    dlw_latch_group #(.W(HI_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .open_n(en_s[3]),
        .d(bus_s[BUS_W-1 -: HI_W]), .q(pre_q)
    );
    dlw_latch_group #(.W(HI_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .open_n(hi_eff_n), .d(hi_d), .q(hi_q)
    );
    dlw_latch_group #(.W(BUS_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .open_n(lo_eff_n), .d(bus_s), .q(lo_q)
    );

    assign code_q = {hi_q, lo_q};

    always_comb begin
        if (bipolar) view_q = {1'b0, code_q} - OFFSET;
        else         view_q = {1'b0, code_q};
    end

    assign mon_en_n = {en_s[3], hi_eff_n, lo_eff_n};

    for (genvar g = 0; g < N_MON; g++) begin : g_mon
        dlw_edge_mon #(
            .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .PW_CYC(PW_CYC)
        ) u_mon (
            .clk(clk), .rst_n(rst_n), .en_n(mon_en_n[g]),
            .data_chg(bus_chg), .viol(mon_viol[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         timing_err <= 1'b0;
        else if (|mon_viol) timing_err <= 1'b1;
        else if (err_clr)   timing_err <= 1'b0;
    end
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
    parameter int CODE_W = 10,
    parameter int HI_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bipolar,
    input logic                     err_clr,
    input logic                     hi_eff_n,
    input logic                     lo_eff_n,
    input logic [CODE_W-1:0]        code_q,
    input logic signed [CODE_W:0]   view_q,
    input logic                     timing_err
);
    localparam int LO_W = CODE_W - HI_W;

    p_msb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_eff_n |=> $stable(code_q[CODE_W-1:LO_W]));

    p_lsb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_eff_n |=> $stable(code_q[LO_W-1:0]));

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_err && !err_clr) |=> timing_err);

    p_unipolar_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bipolar |-> !view_q[CODE_W]);

    p_bipolar_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bipolar |-> (view_q[CODE_W] == !code_q[CODE_W-1]));

    p_bipolar_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bipolar |-> (view_q[CODE_W] == view_q[CODE_W-1]));

    p_bipolar_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bipolar && code_q == (CODE_W)'(1 << (CODE_W - 1))) |-> (view_q == '0));
endmodule

bind dac_word_latch dlw_checker #(.CODE_W(CODE_W), .HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .err_clr(err_clr),
    .hi_eff_n(hi_eff_n), .lo_eff_n(lo_eff_n), .code_q(code_q),
    .view_q(view_q), .timing_err(timing_err)
);

// File: tb/sim_dac_word_latch.sv
module sim_dac_word_latch;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        bus_d;
    logic              hi_open_n, lo_open_n, pre_n, load_n, bipolar, err_clr;
    logic [9:0]        code_q;
    logic signed [10:0] view_q;
    logic              timing_err;
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    dac_word_latch u0 (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .hi_open_n(hi_open_n),
        .lo_open_n(lo_open_n), .pre_n(pre_n), .load_n(load_n),
        .bipolar(bipolar), .err_clr(err_clr), .code_q(code_q),
        .view_q(view_q), .timing_err(timing_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_err();
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        check("R13 cleared by err_clr", int'(timing_err), 0);
    endtask

    task automatic t_reset();
        check("R1 code after reset", int'(code_q), 0);
        check("R1 view after reset", int'(view_q), 0);
        check("R1 error after reset", int'(timing_err), 0);
    endtask

    task automatic t_two_step();
        bus_d = 8'h80; tick(3);
        hi_open_n = 1'b0; tick(10);
        check("R2 upper bits follow bus lines 7:6", int'(code_q), 'h200);
        hi_open_n = 1'b1; tick(6);
        bus_d = 8'h3C; tick(6);
        check("R4 bus ignored while strobes high", int'(code_q), 'h200);
        lo_open_n = 1'b0; tick(10);
        check("R3 lower bits follow bus", int'(code_q), 'h23C);
        lo_open_n = 1'b1; tick(6);
        bus_d = 8'hFF; tick(6);
        check("R5 two-step word held", int'(code_q), 'h23C);
        check("R8 unipolar view", int'(view_q), 572);
        check("R10 no flag on clean writes", int'(timing_err), 0);
    endtask

    task automatic t_latency();
        lo_open_n = 1'b0; tick(6);
        check("R3 transparent lower group", int'(code_q), 'h2FF);
        bus_d = 8'h12; tick(2);
        check("R7 not yet after two edges", int'(code_q), 'h2FF);
        tick(1);
        check("R7 visible at third edge", int'(code_q), 'h212);
        bus_d = 8'h34; tick(3);
        check("R3 tracks second change", int'(code_q), 'h234);
        tick(6); lo_open_n = 1'b1; tick(8);
        check("R12 long pulse not flagged", int'(timing_err), 0);
    endtask

    task automatic t_preload();
        bus_d = 8'h40; tick(3);
        pre_n = 1'b0; tick(10);
        check("R6 pre-load leaves code", int'(code_q), 'h234);
        pre_n = 1'b1; tick(6);
        bus_d = 8'h5A; tick(6);
        load_n = 1'b0; tick(2);
        check("R6 no partial change before latency", int'(code_q), 'h234);
        tick(1);
        check("R6 all ten bits in one cycle", int'(code_q), 'h15A);
        tick(9); load_n = 1'b1; tick(6);
        bus_d = 8'hC3; tick(6);
        check("R4 single-step word held", int'(code_q), 'h15A);
        check("R11 no flag on clean single step", int'(timing_err), 0);
    endtask

    task automatic write_word(input logic [9:0] w);
        bus_d = {w[9:8], 6'b0}; tick(3);
        pre_n = 1'b0; tick(10); pre_n = 1'b1; tick(6);
        bus_d = w[7:0]; tick(6);
        load_n = 1'b0; tick(10); load_n = 1'b1; tick(6);
    endtask

    task automatic t_bipolar();
        bipolar = 1'b1;
        write_word(10'h000);
        check("R9 code 0 is -512", int'(view_q), -512);
        write_word(10'h200);
        check("R9 code 512 is 0", int'(view_q), 0);
        write_word(10'h3FF);
        check("R9 code 1023 is 511", int'(view_q), 511);
        bipolar = 1'b0; tick(1);
        check("R8 unipolar 1023", int'(view_q), 1023);
        check("R5 word after writes", int'(code_q), 'h3FF);
    endtask

    task automatic t_setup_viol();
        lo_open_n = 1'b0; tick(10);
        bus_d = 8'h01; tick(1);
        lo_open_n = 1'b1; tick(8);
        check("R10 setup violation flagged", int'(timing_err), 1);
        tick(10);
        check("R13 flag sticky", int'(timing_err), 1);
        clear_err();
    endtask

    task automatic t_hold_viol();
        tick(6);
        lo_open_n = 1'b0; tick(10);
        lo_open_n = 1'b1; tick(1);
        bus_d = 8'h02; tick(8);
        check("R11 hold violation flagged", int'(timing_err), 1);
        clear_err();
    endtask

    task automatic t_pw_viol();
        tick(6);
        lo_open_n = 1'b0; tick(3);
        lo_open_n = 1'b1; tick(8);
        check("R12 short pulse flagged", int'(timing_err), 1);
        clear_err();
    endtask

    initial begin
        rst_n = 1'b1; bus_d = 8'h00;
        hi_open_n = 1'b1; lo_open_n = 1'b1; pre_n = 1'b1; load_n = 1'b1;
        bipolar = 1'b0; err_clr = 1'b0;
        #5 rst_n = 1'b0;
        tick(3); rst_n = 1'b1; tick(2);
        t_reset();
        t_two_step();
        t_latency();
        t_preload();
        t_bipolar();
        t_setup_viol();
        t_hold_viol();
        t_pw_viol();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule